// File: doc/BRIEF.md
# Low-Discrepancy Stochastic Bit Generator

This block turns an unsigned binary probability into a unipolar stochastic bit stream whose ones are spread evenly over the stream. Its random source is not a shift-register generator. A free-running index counter instead selects, bit by bit, a bank of constant direction vectors. The XOR (modulo-2 sum) of the selected vectors gives the current sequence value. That value is compared with the probability, which yields one stream bit per clock.

A pulse on `start` captures the probability and the choice of vector set and clears the index. The block then emits 2^IDX_W qualified bits and raises `streamDone` on the last one. Two vector sets are built in: a base-2 radical-inverse set, whose vector k has only bit IDX_W-1-k set, and a Pascal-triangle set of the Sobol kind. Stochastic inputs that must stay uncorrelated should use different sets.

Top module: `ldsng_top`

## Requirements
- R1: While reset is held, and after it is released with no start, `streamBit`, `streamValid` and `streamDone` are all 0.
- R2: `start` high at a clock edge clears the index to 0, and the next cycle carries index 0. Each following cycle advances the index by one, so a stream has exactly 2^IDX_W cycles with `streamValid` high.
- R3: `streamDone` is high for exactly one cycle, together with the bit of the final index (all ones). In the next cycle `streamValid` is low unless a new start was taken.
- R4: `streamBit` is 1 only when the sequence value is strictly less than the captured probability. A probability of 0 gives a stream of all zeros.
- R5: Over one full stream, the number of ones equals the captured probability exactly, for both vector sets.
- R6: With `vecSel` = 0 (radical-inverse set), the sequence value for index k is k with its IDX_W bits in reversed order.
- R7: With `vecSel` = 1, vector 0 has only the MSB set, and vector k equals vector k-1 XOR (vector k-1 shifted right by one). The sequence value is the XOR of vector k over every set bit k of the index.
- R8: `probIn` and `vecSel` are captured only when `start` is taken. Changes to them during a stream have no effect on that stream's bits.
- R9: A `start` during a stream, including the cycle in which `streamDone` is high, restarts from index 0 with the new inputs. No idle cycle is inserted.
- R10: A probability of 2^IDX_W-1 gives a stream of all ones except the single bit whose sequence value is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a new stream; captures probIn and vecSel |
| probIn | input | IDX_W | Unsigned probability, value/2^IDX_W |
| vecSel | input | 1 | Direction-vector set: 0 radical inverse, 1 Pascal/Sobol kind |
| streamBit | output | 1 | Stochastic bit of the current index |
| streamValid | output | 1 | High on each cycle that carries a stream bit |
| streamDone | output | 1 | High with the bit of the final index |

## Verification
The interesting collision is a new `start` landing in the cycle that already shows `streamDone`. In that cycle the control must choose between stopping and restarting. The bench provokes it by issuing streams back to back, so each new start falls exactly on the final bit of the previous one. It also cuts a stream short mid-way. The scoreboard expects the old stream's last bit with `streamDone` high, followed at once by index 0 of the new stream, and it checks both the bit order and the ones count of every full stream.

// File: rtl/ldsng_pkg.sv
package ldsng_pkg;

  typedef enum logic {
    SET_RADINV = 1'b0,
    SET_PASCAL = 1'b1
  } vecSet_e;

  typedef struct packed {
    logic clear;
    logic advance;
  } idxStrobe_t;

endpackage

// File: rtl/ldsng_ctrl.sv
module ldsng_ctrl
  import ldsng_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       lastIdx,
  output idxStrobe_t strobe,
  output logic       running,
  output logic       doneOut
);

  logic runQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ <= 1'b0;
    end else if (start) begin
      runQ <= 1'b1;
    end else if (runQ && lastIdx) begin
      runQ <= 1'b0;
    end
  end

  always_comb begin
    strobe.clear   = start;
    strobe.advance = runQ && !start;
  end

  assign running = runQ;
  assign doneOut = runQ && lastIdx;

  AST_DONE_QUALIFIED: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |-> running); // R3

  AST_STOP_AFTER_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (doneOut && !start) |=> !running); // R3

  AST_START_RUNS: assert property (@(posedge clk) disable iff (!rstN)
    start |=> running); // R9

endmodule

// File: rtl/ldsng_datapath.sv
module ldsng_datapath
  import ldsng_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  idxStrobe_t       strobe,
  input  logic             running,
  input  logic [IDX_W-1:0] probIn,
  input  logic             setIn,
  output logic             lastIdx,
  output logic             bitOut
);

  logic [IDX_W-1:0] idxQ;
  logic [IDX_W-1:0] probQ;
  vecSet_e          setQ;
  logic [IDX_W-1:0] seqVal;
  logic [IDX_W-1:0] radVec [IDX_W];
  logic [IDX_W-1:0] pasVec [IDX_W];

  function automatic logic [IDX_W-1:0] pascalDir(input int k);
    logic [IDX_W-1:0] v;
    v = {1'b1, {(IDX_W-1){1'b0}}};
    for (int j = 1; j <= k; j++) v = v ^ (v >> 1);
    return v;
  endfunction

  for (genvar k = 0; k < IDX_W; k++) begin : g_vec
    assign radVec[k] = IDX_W'(1) << (IDX_W - 1 - k);
    assign pasVec[k] = pascalDir(k);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idxQ  <= '0;
      probQ <= '0;
      setQ  <= SET_RADINV;
    end else if (strobe.clear) begin
      idxQ  <= '0;
      probQ <= probIn;
      setQ  <= vecSet_e'(setIn);
    end else if (strobe.advance) begin
      idxQ  <= idxQ + 1'b1;
    end
  end

  always_comb begin
    seqVal = '0;
    for (int k = 0; k < IDX_W; k++) begin
      if (idxQ[k]) seqVal = seqVal ^ ((setQ == SET_PASCAL) ? pasVec[k] : radVec[k]);
    end
  end

  assign lastIdx = &idxQ;
  assign bitOut  = running && (seqVal < probQ);

  AST_CLEAR_TO_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> (idxQ == '0)); // R2

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance |=> (idxQ == $past(idxQ) + 1'b1)); // R2

  AST_PROB_HELD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance |=> ($stable(probQ) && $stable(setQ))); // R8

  AST_ZERO_PROB_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (probQ == '0) |-> !bitOut); // R4

endmodule

// File: rtl/ldsng_top.sv
module ldsng_top
  import ldsng_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [IDX_W-1:0] probIn,
  input  logic             vecSel,
  output logic             streamBit,
  output logic             streamValid,
  output logic             streamDone
);

  idxStrobe_t strobe;
  logic       running;
  logic       lastIdx;

  ldsng_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .lastIdx (lastIdx),
    .strobe  (strobe),
    .running (running),
    .doneOut (streamDone)
  );

  ldsng_datapath #(.IDX_W(IDX_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .running (running),
    .probIn  (probIn),
    .setIn   (vecSel),
    .lastIdx (lastIdx),
    .bitOut  (streamBit)
  );

  assign streamValid = running;

endmodule

// File: tb/ldsng_top_test.sv
module ldsng_top_test;

  localparam int IDX_W = 8;
  localparam int FULL  = 1 << IDX_W;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             start = 1'b0;
  logic [IDX_W-1:0] probIn = '0;
  logic             vecSel = 1'b0;
  logic             streamBit, streamValid, streamDone;

  int nChecks = 0;
  int nFails  = 0;

  typedef struct {
    logic  bitV;
    logic  first;
    logic  last;
    int    ones;
    string tag;
  } item_t;

  item_t q[$];

  always #4 clk = ~clk;

  ldsng_top #(.IDX_W(IDX_W)) uut (
    .clk(clk), .rstN(rstN), .start(start), .probIn(probIn), .vecSel(vecSel),
    .streamBit(streamBit), .streamValid(streamValid), .streamDone(streamDone)
  );

  // R6 and R7: expected sequence value from the requirement text
  function automatic int expSeq(input int k, input int s);
    int r = 0;
    int v;
    if (s == 0) begin
      for (int b = 0; b < IDX_W; b++) if (k[b]) r |= 1 << (IDX_W - 1 - b);
    end else begin
      v = 1 << (IDX_W - 1);
      for (int b = 0; b < IDX_W; b++) begin
        if (k[b]) r ^= v;
        v = v ^ (v >> 1);
      end
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic runStream(input int p, input int s, input int len, input bit scramble, input string tag);
    item_t it;
    for (int k = 0; k < len; k++) begin
      it.bitV  = (expSeq(k, s) < p);
      it.first = (k == 0);
      it.last  = (k == FULL - 1);
      it.ones  = p;
      it.tag   = tag;
      q.push_back(it);
    end
    start  = 1'b1;
    probIn = IDX_W'(p);
    vecSel = s[0];
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    if (scramble) begin // R8: disturb inputs after capture
      probIn = ~IDX_W'(p);
      vecSel = ~s[0];
    end
    repeat (len - 1) @(negedge clk);
  endtask

  task automatic idle(input int n);
    start = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pops expected items as valid bits appear
  int onesAcc = 0;
  int validAcc = 0;
  always @(negedge clk) begin
    if (rstN) begin
      if (streamValid) begin
        if (q.size() == 0) begin
          check(1'b0, "R2 unexpected valid bit", 1, 0);
        end else begin
          item_t it;
          it = q.pop_front();
          if (it.first) begin
            onesAcc = 0;
            validAcc = 0;
          end
          onesAcc += int'(streamBit);
          validAcc++;
          check(streamBit == it.bitV, it.tag, int'(streamBit), int'(it.bitV));
          check(streamDone == it.last, "R3 done flag", int'(streamDone), int'(it.last));
          if (it.last) begin
            check(onesAcc == it.ones, "R5 ones count", onesAcc, it.ones);
            check(validAcc == FULL, "R2 stream length", validAcc, FULL);
          end
        end
      end else begin
        check(!streamDone && !streamBit, "R3 idle outputs", int'({streamDone, streamBit}), 0);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs quiet during reset
    check(!streamValid && !streamDone && !streamBit, "R1 reset outputs",
          int'({streamValid, streamDone, streamBit}), 0);
    rstN = 1'b1;
    idle(3);
    check(!streamValid && !streamDone && !streamBit, "R1 after reset",
          int'({streamValid, streamDone, streamBit}), 0);

    runStream(0, 0, FULL, 1'b0, "R4 zero prob");
    idle(4);
    runStream(100, 0, FULL, 1'b0, "R6 radical inverse");
    runStream(100, 1, FULL, 1'b0, "R7 pascal set, R9 restart on done");
    runStream(255, 1, FULL, 1'b0, "R10 max prob pascal");
    idle(3);
    runStream(37, 1, FULL, 1'b1, "R8 inputs disturbed");
    runStream(200, 0, 40, 1'b0, "R9 cut short");
    runStream(128, 1, FULL, 1'b0, "R9 after cut");
    runStream(255, 0, FULL, 1'b0, "R10 max prob radinv");
    idle(2);
    runStream(1, 0, FULL, 1'b1, "R6 single one");
    runStream(173, 1, FULL, 1'b0, "R7 odd prob");
    idle(5);
    check(q.size() == 0, "R2 leftover expected bits", q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog R2 actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule